// File: doc/BRIEF.md
# DMA Channel Event and Interrupt Controller

This block keeps the control and status state of one DMA channel. Software writes a configuration word that holds the enable, circular-mode and interrupt-mask bits, together with a transfer count. The datapath reports each finished beat and each bus error with one-cycle strobes. The block counts the remaining beats down from the programmed count and detects three events: the half-way point, completion, and bus error. It records each event in a sticky flag and drives one interrupt line from the flags that software has unmasked.

A bus error while the channel is active stops the channel at once and sets the error flag. On completion the channel stops, unless circular mode is set. In circular mode the count reloads and the channel keeps running. Software clears flags by writing ones to a clear port. If hardware sets a flag in the same cycle that software clears it, the flag stays set, so no event is lost.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After reset, active_o is 0, flags_o is 0, remain_o is 0 and irq_o is 0.
- R2: A configuration write loads remain_o with cfg_count_i in the next cycle. active_o becomes cfg_en_i, except that a zero count always leaves active_o at 0.
- R3: While active_o is 1, each beat_done_i pulse lowers remain_o by one. While active_o is 0, beat_done_i has no effect on remain_o.
- R4: Flag bit 0 (half) is set when a beat brings remain_o to floor(N/2), where N is the programmed count. With N = 1, the half and completion flags are therefore set by the same beat.
- R5: Flag bit 1 (completion) is set when a beat brings remain_o to zero. Without circular mode, active_o then falls to 0.
- R6: In circular mode (cfg_circ_i = 1 at the last configuration write), the beat that completes the transfer reloads remain_o with N, and active_o stays 1.
- R7: A bus_err_i pulse while active_o is 1 clears active_o, sets flag bit 2 (error), and cancels any beat in the same cycle. While active_o is 0, bus_err_i has no effect.
- R8: Flags are sticky. A 1 on flag_clr_i[i] clears flag i. A flag that hardware sets in the same cycle as it is cleared stays 1.
- R9: irq_o is the OR, over bits i = 0..2, of flags_o[i] AND the mask bit cfg_ie_i[i] latched at the last configuration write. Bit 0 is half, bit 1 is completion, bit 2 is error. A configuration write does not change flags_o.
- R10: A configuration write takes priority over beat_done_i and bus_err_i in the same cycle. Both strobes are then ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_en_i | input | 1 | Channel enable value to write |
| cfg_circ_i | input | 1 | Circular mode value to write |
| cfg_ie_i | input | 3 | Interrupt mask to write (bit 0 half, bit 1 completion, bit 2 error) |
| cfg_count_i | input | CNT_W | Transfer count to write |
| flag_clr_i | input | 3 | Write-one-to-clear for each flag |
| beat_done_i | input | 1 | One beat finished |
| bus_err_i | input | 1 | The current access returned a bus error |
| active_o | output | 1 | Channel enabled |
| flags_o | output | 3 | Event flags (bit 0 half, bit 1 completion, bit 2 error) |
| remain_o | output | CNT_W | Beats still to transfer |
| irq_o | output | 1 | Interrupt request |

## Verification
Four properties hold on every cycle:
- a bus error while the channel is active stops it and leaves the error flag set;
- a flag that is set stays set through a simultaneous clear;
- a flag with neither a set nor a clear keeps its value;
- the remaining count never decrements from zero, and holds while the channel is idle and no configuration write occurs.

Only the directed scenarios show the arithmetic of the half-way point for even, odd and unit counts, circular reload, the masking of each interrupt source, and which input wins when a configuration write, a beat and an error arrive in the same cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int NUM_EVT  = 3;
  localparam int EVT_HALF = 0;
  localparam int EVT_DONE = 1;
  localparam int EVT_ERR  = 2;
  typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/dma_chan_counter.sv
module dma_chan_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  input  logic             circ_i,
  output logic [CNT_W-1:0] remain_o,
  output logic             half_hit_o,
  output logic             zero_hit_o
);
  logic [CNT_W-1:0] reload_q, remain_q, next_cnt, half_pt;

  assign next_cnt   = remain_q - CNT_W'(1);
  assign half_pt    = reload_q >> 1;
  assign half_hit_o = dec_i && (next_cnt == half_pt);
  assign zero_hit_o = dec_i && (next_cnt == '0);
  assign remain_o   = remain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reload_q <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      reload_q <= load_val_i;
      remain_q <= load_val_i;
    end else if (dec_i) begin
      remain_q <= (zero_hit_o && circ_i) ? reload_q : next_cnt;
    end
  end

  // R3: never count below zero
  a_r3_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_i |-> remain_q != '0);
  a_r3_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !dec_i) |=> $stable(remain_q));
endmodule

// File: rtl/dma_chan_flags.sv
module dma_chan_flags
  import dma_chan_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  evt_vec_t set_i,
  input  evt_vec_t clr_i,
  input  evt_vec_t ie_i,
  output evt_vec_t flags_o,
  output logic     irq_o
);
  evt_vec_t flag_q;

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       flag_q[i] <= 1'b0;
      else if (set_i[i]) flag_q[i] <= 1'b1;  // set beats clear
      else if (clr_i[i]) flag_q[i] <= 1'b0;
    end

    // R8: set wins over clear; untouched flags hold
    a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> flag_q[i]);
    a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(flag_q[i]));
  end

  assign flags_o = flag_q;
  assign irq_o   = |(flag_q & ie_i);
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_en_i,
  input  logic               cfg_circ_i,
  input  logic [NUM_EVT-1:0] cfg_ie_i,
  input  logic [CNT_W-1:0]   cfg_count_i,
  input  logic [NUM_EVT-1:0] flag_clr_i,
  input  logic               beat_done_i,
  input  logic               bus_err_i,
  output logic               active_o,
  output logic [NUM_EVT-1:0] flags_o,
  output logic [CNT_W-1:0]   remain_o,
  output logic               irq_o
);
  logic     en_q, circ_q;
  evt_vec_t ie_q, evt_set;
  logic     beat_acc, err_evt, half_hit, zero_hit;

  assign err_evt  = en_q && bus_err_i && !cfg_we_i;
  assign beat_acc = en_q && beat_done_i && !bus_err_i && !cfg_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      circ_q <= 1'b0;
      ie_q   <= '0;
    end else if (cfg_we_i) begin
      en_q   <= cfg_en_i && (cfg_count_i != '0);
      circ_q <= cfg_circ_i;
      ie_q   <= cfg_ie_i;
    end else if (err_evt) begin
      en_q <= 1'b0;
    end else if (zero_hit && !circ_q) begin
      en_q <= 1'b0;
    end
  end

  dma_chan_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cfg_we_i),
    .load_val_i (cfg_count_i),
    .dec_i      (beat_acc),
    .circ_i     (circ_q),
    .remain_o   (remain_o),
    .half_hit_o (half_hit),
    .zero_hit_o (zero_hit)
  );

  always_comb begin
    evt_set           = '0;
    evt_set[EVT_HALF] = half_hit;
    evt_set[EVT_DONE] = zero_hit;
    evt_set[EVT_ERR]  = err_evt;
  end

  dma_chan_flags u_flags (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (evt_set),
    .clr_i   (flag_clr_i),
    .ie_i    (ie_q),
    .flags_o (flags_o),
    .irq_o   (irq_o)
  );

  assign active_o = en_q;

  // R7: an error on an active channel stops it and records the error
  a_r7_err_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_o && bus_err_i && !cfg_we_i) |=> (!active_o && flags_o[EVT_ERR]));
  // R3: idle channel ignores beats
  a_r3_idle_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_o && !cfg_we_i) |=> $stable(remain_o));
  // R2: zero count never enables
  a_r2_zero_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_count_i == '0) |=> !active_o);
endmodule

// File: tb/tb_dma_chan_ctrl.sv
module tb_dma_chan_ctrl;
  localparam int CNT_W = 16;
  logic clk = 0, rst_ni = 0;
  logic cfg_we = 0, cfg_en = 0, cfg_circ = 0, beat = 0, err = 0;
  logic [2:0] cfg_ie = 0, clr = 0;
  logic [CNT_W-1:0] cfg_count = 0;
  logic active, irq;
  logic [2:0] flags;
  logic [CNT_W-1:0] remain;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_chan_ctrl #(.CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_en_i(cfg_en),
    .cfg_circ_i(cfg_circ), .cfg_ie_i(cfg_ie), .cfg_count_i(cfg_count),
    .flag_clr_i(clr), .beat_done_i(beat), .bus_err_i(err),
    .active_o(active), .flags_o(flags), .remain_o(remain), .irq_o(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cfg(logic en, logic circ, logic [2:0] ie, int cnt);
    @(negedge clk);
    cfg_we = 1; cfg_en = en; cfg_circ = circ; cfg_ie = ie; cfg_count = CNT_W'(cnt);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic beats(int n);
    @(negedge clk);
    beat = 1;
    repeat (n) @(negedge clk);
    beat = 0;
  endtask

  task automatic clear(logic [2:0] m);
    @(negedge clk);
    clr = m;
    @(negedge clk);
    clr = 0;
  endtask

  task automatic t_reset();
    chk("R1 active", active, 0);
    chk("R1 flags", flags, 0);
    chk("R1 remain", remain, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_config();
    cfg(1, 0, 0, 0);
    chk("R2 zero count inactive", active, 0);
    cfg(1, 0, 0, 6);
    chk("R2 active", active, 1);
    chk("R2 remain", remain, 6);
  endtask

  task automatic t_even();
    beats(2);
    chk("R3 decrement", remain, 4);
    chk("R4 no half yet", flags, 0);
    beats(1);
    chk("R4 half at 3", flags, 3'b001);
    beats(3);
    chk("R5 done flag", flags, 3'b011);
    chk("R5 stops", active, 0);
    chk("R5 remain zero", remain, 0);
  endtask

  task automatic t_idle_and_odd();
    clear(3'b111);
    chk("R8 cleared", flags, 0);
    beats(3);
    chk("R3 idle beats ignored", remain, 0);
    cfg(1, 0, 0, 5);
    beats(2);
    chk("R4 odd no half at 3", flags, 0);
    beats(1);
    chk("R4 odd half at 2", flags, 3'b001);
    clear(3'b111);
    cfg(1, 0, 0, 1);
    beats(1);
    chk("R4 unit count half+done", flags, 3'b011);
    chk("R5 unit stops", active, 0);
  endtask

  task automatic t_circular();
    clear(3'b111);
    cfg(1, 1, 0, 4);
    beats(4);
    chk("R6 reload", remain, 4);
    chk("R6 still active", active, 1);
    chk("R6 done flag", flags, 3'b011);
    beats(1);
    chk("R6 continues", remain, 3);
  endtask

  task automatic t_set_wins();
    clear(3'b111);
    cfg(1, 1, 0, 2);
    beats(2);
    chk("R8 setup", flags, 3'b011);
    @(negedge clk);
    beat = 1; clr = 3'b011;
    @(negedge clk);
    beat = 0; clr = 0;
    chk("R8 set wins, other cleared", flags, 3'b001);
  endtask

  task automatic t_error();
    clear(3'b111);
    cfg(1, 0, 0, 4);
    beats(1);
    @(negedge clk);
    beat = 1; err = 1;
    @(negedge clk);
    beat = 0; err = 0;
    chk("R7 stops", active, 0);
    chk("R7 err flag", flags, 3'b100);
    chk("R7 beat cancelled", remain, 3);
    clear(3'b100);
    @(negedge clk);
    err = 1;
    @(negedge clk);
    err = 0;
    chk("R7 idle error ignored", flags, 0);
  endtask

  task automatic t_irq();
    // flags now 0; create error flag with mask off
    cfg(1, 0, 3'b000, 4);
    @(negedge clk); err = 1; @(negedge clk); err = 0;
    chk("R9 masked", irq, 0);
    cfg(0, 0, 3'b011, 4);
    chk("R9 cfg keeps flags", flags, 3'b100);
    chk("R9 err masked by other bits", irq, 0);
    cfg(0, 0, 3'b100, 4);
    chk("R9 err enabled", irq, 1);
    clear(3'b100);
    cfg(1, 0, 3'b001, 2);
    beats(1);
    chk("R9 half irq", irq, 1);
    cfg(0, 0, 3'b010, 2);
    chk("R9 half masked", irq, 0);
  endtask

  task automatic t_priority();
    clear(3'b111);
    cfg(1, 0, 0, 4);
    @(negedge clk);
    cfg_we = 1; cfg_en = 1; cfg_circ = 0; cfg_ie = 0; cfg_count = 8; beat = 1; err = 1;
    @(negedge clk);
    cfg_we = 0; beat = 0; err = 0;
    chk("R10 remain reloaded", remain, 8);
    chk("R10 active", active, 1);
    chk("R10 no error flag", flags, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    t_reset();
    t_config();
    t_even();
    t_idle_and_odd();
    t_circular();
    t_set_wins();
    t_error();
    t_irq();
    t_priority();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule